// File: doc/BRIEF.md
# Dual-Channel Bus-Master IDE Register File

This block holds the software-visible registers of a two-channel bus-master IDE DMA engine. It sits behind a 16-byte I/O window on a simple register bus. The bus has an address, a size code, a write enable, write data and read data. Each channel gets eight bytes. The first four bytes form a command/status region and the last four hold the 32-bit base address of the descriptor table. The register file also collects interrupt and error event pulses from the drive side of each channel. It drives a start level and a direction level to the DMA engine of each channel.

Bus data is right-justified. A byte access uses bits 7:0 of the data buses and a halfword access uses bits 15:0. The size code is 0 for a byte, 1 for a halfword and 2 or 3 for a dword. Writes take effect on the rising clock edge while the write enable is high. Read data is combinational from the address and size.

Top module: `ide_bm_regfile`

## Requirements
- R1: After reset, every command, status and descriptor-address register reads as zero, and all start and direction outputs are low.
- R2: Channel n occupies window addresses 8n to 8n+7. Within a channel, offset 0 is the command register, offset 2 is the status register and offsets 4 to 7 are the descriptor address. Accesses to one channel never change the other channel.
- R3: In the command/status region, a byte read at offset 1 or 3 returns 0xFF, and a byte write at offset 1 or 3 changes no register.
- R4: In the command/status region, a halfword read returns 0x0000FFFF and a dword read returns 0xFFFFFFFF. A halfword or dword write there changes no register.
- R5: Command bit 0 (start) and bit 3 (direction) are stored. All other command bits read as 0. The stored start and direction bits drive that channel's dma_start and dma_dir outputs.
- R6: A command write sets status bit 0 (active) to the written start bit, whether that bit is 1 or 0.
- R7: A status write loads bits 5 and 6 from the written byte, leaves bit 0 unchanged and forces bits 3, 4 and 7 to 0.
- R8: A status write clears bit 1 or bit 2 where the written bit is 1 and leaves it unchanged where the written bit is 0.
- R9: An interrupt event pulse sets status bit 2 and an error event pulse sets status bit 1. An event wins over a clear written to the same bit in the same cycle.
- R10: The descriptor-address port takes byte, halfword and dword writes and updates only the addressed byte lanes. Reads return the addressed bytes right-justified. Address bits 1:0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address within the window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 dword |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, right-justified |
| irq_evt | input | 2 | Per-channel interrupt event pulse |
| err_evt | input | 2 | Per-channel error event pulse |
| dma_start | output | 2 | Per-channel start level to the DMA engine |
| dma_dir | output | 2 | Per-channel direction level to the DMA engine |

## Verification
The status byte is tested with several write patterns:
- An all-ones write shows the read/write, kept, forced-zero and clear bits in one value.
- A write of 0x04 alone shows that a clear hits only the chosen bit.
- The same write issued in the same cycle as an interrupt pulse shows that the event wins.

The undecoded lanes are tested with byte, halfword and dword accesses, which tell the 0xFF lanes apart from the all-ones wide reads and the ignored wide writes. On the address port, lane-selective writes use different sizes and offsets, which tells a correct byte-enable from a shift or width error.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
   localparam int unsigned DW = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WORD2 = 2'd3
   } acc_size_e;

   localparam logic [7:0] CMD_KEEP  = 8'h09;
   localparam int unsigned CMD_START = 0;
   localparam int unsigned CMD_DIR   = 3;
   localparam int unsigned ST_ACT    = 0;
   localparam int unsigned ST_ERR    = 1;
   localparam int unsigned ST_IRQ    = 2;

   function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    size_mask = 32'h0000_00FF;
         2'd1:    size_mask = 32'h0000_FFFF;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic int unsigned size_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    size_bytes = 1;
         2'd1:    size_bytes = 2;
         default: size_bytes = 4;
      endcase
   endfunction
endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
   import ide_bm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic       sts_we,
   input  logic [7:0] wbyte,
   input  logic       irq_evt,
   input  logic       err_evt,
   output logic [7:0] cmd_q,
   output logic [7:0] sts_q,
   output logic       start,
   output logic       dir
);
   logic [7:0] sts_d;

   always_comb begin
      sts_d = sts_q;
      if (sts_we) begin
         sts_d = {1'b0, wbyte[6:5], 2'b00,
                  sts_q[ST_IRQ:ST_ERR] & ~wbyte[ST_IRQ:ST_ERR], sts_q[ST_ACT]};
      end
      if (cmd_we) sts_d[ST_ACT] = wbyte[CMD_START];
      if (irq_evt) sts_d[ST_IRQ] = 1'b1;
      if (err_evt) sts_d[ST_ERR] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         sts_q <= '0;
      end else begin
         if (cmd_we) cmd_q <= wbyte & CMD_KEEP;
         sts_q <= sts_d;
      end
   end

   assign start = cmd_q[CMD_START];
   assign dir   = cmd_q[CMD_DIR];

   AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt |=> sts_q[ST_IRQ]); // R9
   AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> sts_q[ST_ERR]); // R9
   AST_ACT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |=> sts_q[ST_ACT] == $past(wbyte[CMD_START])); // R6
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_we |=> $stable(cmd_q) && $stable(dir)); // R5
   AST_STS_KEEP_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && !cmd_we) |=> $stable(sts_q[ST_ACT])); // R7
endmodule

// File: rtl/ide_bm_addr_port.sv
module ide_bm_addr_port
   import ide_bm_pkg::*;
#(
   parameter int unsigned ALIGN_BITS = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    off,
   input  logic [1:0]    size,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] base_q
);
   localparam int unsigned NLANE = DW / 8;

   initial begin
      if (ALIGN_BITS >= DW) $error("ALIGN_BITS too large");
   end

   logic [DW-1:0] lane_data;
   logic [NLANE-1:0] be;
   assign lane_data = wdata << (8 * off);

   for (genvar k = 0; k < NLANE; k++) begin : g_be
      assign be[k] = (k >= int'(off)) && (k < int'(off) + size_bytes(size));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (we) begin
         for (int k = 0; k < NLANE; k++) begin
            if (be[k]) base_q[8*k +: 8] <= lane_data[8*k +: 8];
         end
         base_q[ALIGN_BITS-1:0] <= '0;
      end
   end

   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(base_q)); // R10
   AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> base_q[ALIGN_BITS-1:0] == '0); // R10
endmodule

// File: rtl/ide_bm_regfile.sv
module ide_bm_regfile
   import ide_bm_pkg::*;
#(
   parameter int unsigned NCH = 2,
   parameter int unsigned CW  = $clog2(NCH),
   parameter int unsigned AW  = CW + 3
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  bus_addr,
   input  logic [1:0]     bus_size,
   input  logic           bus_we,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   input  logic [NCH-1:0] irq_evt,
   input  logic [NCH-1:0] err_evt,
   output logic [NCH-1:0] dma_start,
   output logic [NCH-1:0] dma_dir
);
   initial begin
      if (NCH < 2) $error("NCH must be at least 2");
      if ((1 << CW) != NCH) $error("NCH must be a power of two");
   end

   logic [CW-1:0] ch_sel;
   logic          in_addr;
   logic [1:0]    off;
   logic          is_byte;

   assign ch_sel  = bus_addr[AW-1:3];
   assign in_addr = bus_addr[2];
   assign off     = bus_addr[1:0];
   assign is_byte = (bus_size == SZ_BYTE);

   logic [7:0]    cmd_a  [NCH];
   logic [7:0]    sts_a  [NCH];
   logic [DW-1:0] base_a [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = bus_we && (ch_sel == CW'(c));

      ide_bm_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd_we  (hit && !in_addr && is_byte && off == 2'd0),
         .sts_we  (hit && !in_addr && is_byte && off == 2'd2),
         .wbyte   (bus_wdata[7:0]),
         .irq_evt (irq_evt[c]),
         .err_evt (err_evt[c]),
         .cmd_q   (cmd_a[c]),
         .sts_q   (sts_a[c]),
         .start   (dma_start[c]),
         .dir     (dma_dir[c])
      );

      ide_bm_addr_port u_addr (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (hit && in_addr),
         .off    (off),
         .size   (bus_size),
         .wdata  (bus_wdata),
         .base_q (base_a[c])
      );
   end

   always_comb begin
      if (in_addr) begin
         bus_rdata = (base_a[ch_sel] >> (8 * off)) & size_mask(bus_size);
      end else if (!is_byte) begin
         bus_rdata = size_mask(bus_size);
      end else begin
         case (off)
            2'd0:    bus_rdata = {24'h0, cmd_a[ch_sel]};
            2'd2:    bus_rdata = {24'h0, sts_a[ch_sel]};
            default: bus_rdata = 32'h0000_00FF;
         endcase
      end
   end

   AST_WIDE_CS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_addr && !is_byte) |-> bus_rdata == size_mask(bus_size)); // R4
   AST_RSVD_LANE_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_addr && is_byte && off[0]) |-> bus_rdata == 32'h0000_00FF); // R3
endmodule

// File: tb/tb_ide_bm_regfile.sv
module tb_ide_bm_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq_evt = '0;
   logic [1:0]  err_evt = '0;
   logic [1:0]  dma_start, dma_dir;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ide_bm_regfile dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_evt(irq_evt), .err_evt(err_evt),
      .dma_start(dma_start), .dma_dir(dma_dir)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [1:0] sz,
                         input logic [31:0] exp);
      bus_addr = a; bus_size = sz;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 16; a += 2) rd_chk("R1", 4'(a), 2'd0, (a % 4 == 0 || a % 4 == 2) ? 32'h0 : 32'hFF);
      rd_chk("R1", 4'd4, 2'd2, 32'h0);
      rd_chk("R1", 4'd12, 2'd2, 32'h0);
      check("R1", {28'h0, dma_start, dma_dir}, 32'h0);
   endtask

   task automatic t_cmd;
      wr(4'd0, 2'd0, 32'hFF);
      rd_chk("R5", 4'd0, 2'd0, 32'h09);
      check("R5", {30'h0, dma_start}, 32'h1);
      check("R5", {30'h0, dma_dir}, 32'h1);
      rd_chk("R6", 4'd2, 2'd0, 32'h01);
   endtask

   task automatic t_status;
      wr(4'd2, 2'd0, 32'hFF);
      rd_chk("R7", 4'd2, 2'd0, 32'h61);
      @(negedge clk); irq_evt = 2'b01; @(negedge clk); irq_evt = 2'b00;
      rd_chk("R9", 4'd2, 2'd0, 32'h65);
      @(negedge clk); err_evt = 2'b01; @(negedge clk); err_evt = 2'b00;
      rd_chk("R9", 4'd2, 2'd0, 32'h67);
      wr(4'd2, 2'd0, 32'h04);
      rd_chk("R8", 4'd2, 2'd0, 32'h03);
      @(negedge clk);
      bus_addr = 4'd2; bus_size = 2'd0; bus_wdata = 32'h04; bus_we = 1'b1; irq_evt = 2'b01;
      @(negedge clk);
      bus_we = 1'b0; irq_evt = 2'b00;
      rd_chk("R9", 4'd2, 2'd0, 32'h07);
   endtask

   task automatic t_odd_lanes;
      rd_chk("R3", 4'd1, 2'd0, 32'hFF);
      rd_chk("R3", 4'd3, 2'd0, 32'hFF);
      wr(4'd1, 2'd0, 32'h00);
      wr(4'd3, 2'd0, 32'hFF);
      rd_chk("R3", 4'd0, 2'd0, 32'h09);
      rd_chk("R3", 4'd2, 2'd0, 32'h07);
   endtask

   task automatic t_wide;
      rd_chk("R4", 4'd0, 2'd1, 32'h0000FFFF);
      rd_chk("R4", 4'd2, 2'd2, 32'hFFFFFFFF);
      wr(4'd0, 2'd1, 32'h0000_0000);
      wr(4'd0, 2'd2, 32'h0000_0000);
      wr(4'd2, 2'd1, 32'h0000_FFFF);
      rd_chk("R4", 4'd0, 2'd0, 32'h09);
      rd_chk("R4", 4'd2, 2'd0, 32'h07);
   endtask

   task automatic t_stop;
      wr(4'd0, 2'd0, 32'h00);
      rd_chk("R6", 4'd2, 2'd0, 32'h06);
      check("R5", {30'h0, dma_start}, 32'h0);
   endtask

   task automatic t_addr;
      wr(4'd12, 2'd2, 32'h12345677);
      rd_chk("R10", 4'd12, 2'd2, 32'h12345674);
      wr(4'd14, 2'd0, 32'h000000AB);
      rd_chk("R10", 4'd12, 2'd2, 32'h12AB5674);
      wr(4'd12, 2'd1, 32'h0000BEEF);
      rd_chk("R10", 4'd12, 2'd2, 32'h12ABBEEC);
      rd_chk("R10", 4'd14, 2'd1, 32'h000012AB);
      rd_chk("R10", 4'd13, 2'd0, 32'h000000BE);
   endtask

   task automatic t_indep;
      rd_chk("R2", 4'd4, 2'd2, 32'h0);
      rd_chk("R2", 4'd8, 2'd0, 32'h0);
      rd_chk("R2", 4'd10, 2'd0, 32'h0);
      wr(4'd8, 2'd0, 32'h08);
      check("R2", {30'h0, dma_dir}, 32'h2);
      check("R2", {30'h0, dma_start}, 32'h0);
      rd_chk("R2", 4'd2, 2'd0, 32'h06);
      rd_chk("R2", 4'd8, 2'd0, 32'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd();
      t_status();
      t_odd_lanes();
      t_wide();
      t_stop();
      t_addr();
      t_indep();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               n_chk++; n_bad++;
               $display("FAIL watchdog: actual hung expected done");
            end
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule